// File: doc/BRIEF.md
# SDRAM Power-Up and Single-Word Access Controller

This block sits between one client and a single-data-rate SDRAM device with four banks, 12-bit rows, 8-bit columns and 16-bit words. Once released from reset it stays quiet until the client pulses an initialization start. It then brings the device up with a counter-timed sequence: a long stable-clock wait with no-operation commands, a precharge of every bank, eight auto-refresh cycles and a mode-register load. After that it serves single-word reads and writes.

Every access opens the addressed row, waits the row-to-column delay, issues one column command and closes the bank again with a precharge. An interval counter asks for a refresh at a fixed period. The controller serves that refresh between accesses. The client sees a single `busy` line. A request offered while `busy` is low is taken on that clock edge. Read data comes back with a one-cycle valid strobe.

Top module: `sdram_ctl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `sd_cke` is low, `sd_cs_n`, `sd_ras_n`, `sd_cas_n` and `sd_we_n` are high, `busy` is high, and `rd_valid` and `rd_data` are zero.
- R2: Until `init_start` is seen, chip select stays high and CKE stays low. After the start, CKE rises and at least `P_WAIT_CYC` no-operation cycles pass before any other command.
- R3: Power-up issues exactly one precharge with address bit 10 high, then exactly `P_REF_NUM` auto-refresh commands, then the mode-register load. The first refresh comes at least `P_PRE_CYC` cycles after the precharge. Each later refresh, and the mode load, comes at least `P_REF_CYC` cycles after the refresh before it.
- R4: The mode-register load drives bank address 0 and address value `P_CL << 4`: burst length 1 in bits 2:0 (value 000), sequential order (bit 3 = 0) and CAS latency in bits 6:4. No activate, read or write appears before it, and `busy` stays high until it has completed.
- R5: Commands use the active-low tuple {CS#,RAS#,CAS#,WE#}: 0111 no-op, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode load, and CS# high means deselect. No other code is ever driven.
- R6: An access first activates `req_bank`/`req_row`. A column command with the column on address bits 7:0 and bit 10 low follows at least `P_TRCD` cycles later.
- R7: The data bus carries `req_wdata` on the write command cycle only. A later read of the same location returns that word.
- R8: For a read, `rd_valid` is high for exactly one cycle. Data is sampled `P_CL` clocks after the device receives the read command, so `rd_valid` rises `P_CL`+1 edges after that command reaches the pins.
- R9: After power-up, refreshes are issued at intervals of no more than `P_REFI_CYC` cycles plus one access. `busy` is high while a refresh runs.
- R10: Each access ends with a precharge of the accessed bank (bit 10 low). It comes at least `P_TRAS` cycles after the activate and, for a write, at least `P_TWR` cycles after the write command.
- R11: A request presented while `busy` is high is ignored, and the addressed word keeps its contents.
- R12: The read/write choice and the write data are latched when the request is accepted. Changes to `req_we` or `req_wdata` after that edge do not alter the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller and device clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_start | input | 1 | Starts the power-up sequence |
| req | input | 1 | Access request, taken when busy is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank of the access |
| req_row | input | 12 | Row of the access |
| req_col | input | 8 | Column of the access |
| req_wdata | input | 16 | Word to write |
| busy | output | 1 | High while a request would not be accepted |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| rd_data | output | 16 | Read word |
| sd_cke | output | 1 | Device clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Multiplexed row/column/mode address |
| sd_dq | inout | 16 | Bidirectional data bus |

## Verification
A wrong phase or count in the power-up sequencer shows at the pins within one phase. The bench sees a refresh too early, a missing or extra precharge-all, or a wrong mode word, and `busy` never falls. If the access state machine skips the row-delay wait or closes a bank early, the column command or the precharge appears too close to the activate. That shows on the same access. A slip in the read-capture pipeline either returns the wrong word or moves `rd_valid` off its fixed distance from the read command, on the first read.

// File: rtl/sdram_ctl_pkg.sv
// Shared widths, command codes and the registered command bundle.
// Assumes a single device with four banks and a 16-bit data word.
package sdram_ctl_pkg;
    localparam int BA_W   = 2;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 8;
    localparam int DQ_W   = 16;
    localparam int ADDR_W = ROW_W;
    localparam int AP_BIT = 10;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111,
        CMD_DES = 4'b1111
    } sd_cmd_e;

    typedef struct packed {
        sd_cmd_e             cmd;
        logic [BA_W-1:0]     ba;
        logic [ADDR_W-1:0]   addr;
    } sd_bus_t;
endpackage

// File: rtl/sdram_init_seq.sv
// Power-up sequencer: after a start pulse it raises CKE, sends NOPs for the
// stable wait, then precharge-all, a fixed number of refreshes and the mode
// load, each phase timed by one shared counter. Assumes all phase lengths
// are no larger than the stable wait. Outputs are next-cycle values.
module sdram_init_seq import sdram_ctl_pkg::*; #(
    parameter int P_WAIT_CYC = 25000,
    parameter int P_PRE_CYC  = 20,
    parameter int P_REF_CYC  = 20,
    parameter int P_REF_NUM  = 8,
    parameter int P_MRD_CYC  = 2,
    parameter int P_CL       = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    output logic    cke_nxt,
    output sd_bus_t bus_nxt,
    output logic    done
);
    localparam int CNT_W = $clog2(P_WAIT_CYC + 1);
    localparam int RN_W  = $clog2(P_REF_NUM + 1);
    localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(P_CL << 4);

    typedef enum logic [2:0] {I_IDLE, I_WAIT, I_PRE, I_REF, I_MRS, I_DONE} ist_e;

    ist_e             state;
    logic [CNT_W-1:0] cnt;
    logic [RN_W-1:0]  refn;

    // Phase sequencing and per-phase cycle counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= I_IDLE;
            cnt   <= '0;
            refn  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
            unique case (state)
                I_IDLE: begin
                    cnt <= '0;
                    if (start) state <= I_WAIT;
                end
                I_WAIT: if (cnt == CNT_W'(P_WAIT_CYC - 1)) begin
                    state <= I_PRE;
                    cnt   <= '0;
                end
                I_PRE: if (cnt == CNT_W'(P_PRE_CYC - 1)) begin
                    state <= I_REF;
                    cnt   <= '0;
                    refn  <= '0;
                end
                I_REF: if (cnt == CNT_W'(P_REF_CYC - 1)) begin
                    cnt <= '0;
                    if (refn == RN_W'(P_REF_NUM - 1)) state <= I_MRS;
                    else refn <= refn + 1'b1;
                end
                I_MRS: if (cnt == CNT_W'(P_MRD_CYC - 1)) begin
                    state <= I_DONE;
                    cnt   <= '0;
                end
                default: cnt <= '0;
            endcase
        end
    end

    // Command selection for the current phase.
    always_comb begin
        bus_nxt = '{cmd: CMD_NOP, ba: '0, addr: '0};
        unique case (state)
            I_IDLE: bus_nxt.cmd = CMD_DES;
            I_PRE: if (cnt == '0) begin
                bus_nxt.cmd          = CMD_PRE;
                bus_nxt.addr[AP_BIT] = 1'b1;
            end
            I_REF: if (cnt == '0) bus_nxt.cmd = CMD_REF;
            I_MRS: if (cnt == '0) begin
                bus_nxt.cmd  = CMD_MRS;
                bus_nxt.addr = MODE_WORD;
            end
            default: ;
        endcase
    end

    assign cke_nxt = (state != I_IDLE);
    assign done    = (state == I_DONE);
endmodule

// File: rtl/sdram_refresh_timer.sv
// Refresh interval timer: once enabled, raises a pending flag every
// P_REFI_CYC cycles; the flag holds until acknowledged. Assumes the
// acknowledge never arrives more often than the interval.
module sdram_refresh_timer #(
    parameter int P_REFI_CYC = 975
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ack,
    output logic pend
);
    localparam int CNT_W = $clog2(P_REFI_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic             wrap;

    assign wrap = en && (cnt == CNT_W'(P_REFI_CYC - 1));

    // Free-running interval count and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (!en || wrap) cnt <= '0;
            else             cnt <= cnt + 1'b1;
            if (wrap)     pend <= 1'b1;
            else if (ack) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/sdram_access_fsm.sv
// Access engine: serves one pending refresh or one single-word request at a
// time. Activate, wait tRCD, column command by the latched tag, hold for
// tWR or CL and tRAS, precharge the bank, wait tRP. Also tracks when read
// data must be sampled. Assumes every bank is closed whenever it is idle.
module sdram_access_fsm import sdram_ctl_pkg::*; #(
    parameter int P_TRCD = 2,
    parameter int P_CL   = 2,
    parameter int P_TWR  = 2,
    parameter int P_TRAS = 6,
    parameter int P_TRP  = 3,
    parameter int P_TRFC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_done,
    input  logic             req,
    input  logic             req_we,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [DQ_W-1:0]  req_wdata,
    input  logic             ref_pend,
    output logic             ref_ack,
    output logic             busy,
    output sd_bus_t          bus_nxt,
    output logic             dq_oe_nxt,
    output logic [DQ_W-1:0]  wdata_q,
    output logic             rd_sample
);
    localparam int M1    = (P_TRFC > P_TRP) ? P_TRFC : P_TRP;
    localparam int M2    = (P_TWR > P_CL) ? P_TWR : P_CL;
    localparam int M3    = (M1 > M2) ? M1 : M2;
    localparam int MAXT  = (M3 > P_TRCD) ? M3 : P_TRCD;
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam int RAS_W = $clog2(P_TRAS + 1) + 1;

    typedef enum logic [2:0] {A_IDLE, A_REF, A_ACT, A_RCD, A_COL, A_HOLD, A_PRE, A_RP} ast_e;

    ast_e             state;
    logic [CNT_W-1:0] cnt;
    logic [RAS_W-1:0] ras_cnt;
    logic             we_q;
    logic             rcd_done;
    logic [BA_W-1:0]  bank_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [P_CL:0]    rd_sr;
    logic [CNT_W-1:0] hold_last;
    logic             accept;

    assign busy      = !(state == A_IDLE && init_done && !ref_pend);
    assign ref_ack   = (state == A_IDLE) && init_done && ref_pend;
    assign accept    = req && !busy;
    assign hold_last = we_q ? CNT_W'(P_TWR - 1) : CNT_W'(P_CL - 1);

    // Main access sequencing, request latching and delay counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= A_IDLE;
            cnt      <= '0;
            we_q     <= 1'b0;
            rcd_done <= 1'b0;
            bank_q   <= '0;
            row_q    <= '0;
            col_q    <= '0;
            wdata_q  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
            unique case (state)
                A_IDLE: begin
                    cnt <= '0;
                    if (ref_ack) state <= A_REF;
                    else if (accept) begin
                        state   <= A_ACT;
                        we_q    <= req_we;
                        bank_q  <= req_bank;
                        row_q   <= req_row;
                        col_q   <= req_col;
                        wdata_q <= req_wdata;
                    end
                end
                A_REF: if (cnt >= CNT_W'(P_TRFC - 1)) state <= A_IDLE;
                A_ACT: begin
                    state    <= A_RCD;
                    cnt      <= CNT_W'(1);
                    rcd_done <= 1'b0;
                end
                A_RCD: if (cnt >= CNT_W'(P_TRCD - 1)) begin
                    state    <= A_COL;
                    rcd_done <= 1'b1;
                end
                A_COL: begin
                    state <= A_HOLD;
                    cnt   <= CNT_W'(1);
                end
                A_HOLD: if (cnt >= hold_last && ras_cnt >= RAS_W'(P_TRAS - 1)) state <= A_PRE;
                A_PRE: begin
                    state    <= A_RP;
                    cnt      <= CNT_W'(1);
                    rcd_done <= 1'b0;
                end
                A_RP: if (cnt >= CNT_W'(P_TRP - 1)) state <= A_IDLE;
                default: state <= A_IDLE;
            endcase
        end
    end

    // Cycles since the last activate, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ras_cnt <= '0;
        else if (state == A_ACT)     ras_cnt <= RAS_W'(1);
        else if (ras_cnt != '1)      ras_cnt <= ras_cnt + 1'b1;
    end

    // Read sample pipeline: bit P_CL marks the edge where data is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_sr <= '0;
        else        rd_sr <= {rd_sr[P_CL-1:0], (state == A_COL) && rcd_done && !we_q};
    end
    assign rd_sample = rd_sr[P_CL];

    // Command for the current state.
    always_comb begin
        bus_nxt   = '{cmd: CMD_NOP, ba: bank_q, addr: '0};
        dq_oe_nxt = 1'b0;
        unique case (state)
            A_REF: if (cnt == '0) bus_nxt.cmd = CMD_REF;
            A_ACT: begin
                bus_nxt.cmd  = CMD_ACT;
                bus_nxt.addr = row_q;
            end
            A_COL: if (rcd_done) begin
                bus_nxt.cmd  = we_q ? CMD_WR : CMD_RD;
                bus_nxt.addr = ADDR_W'(col_q);
                dq_oe_nxt    = we_q;
            end
            A_PRE: bus_nxt.cmd = CMD_PRE;
            default: ;
        endcase
    end

    // R6: the column command never comes before tRCD has elapsed since activate.
    assert_col_after_rcd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == A_COL) |-> (ras_cnt >= RAS_W'(P_TRCD)));

    // R10: the closing precharge respects the minimum row-active time.
    assert_pre_after_tras_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == A_PRE) |-> (ras_cnt >= RAS_W'(P_TRAS)));
endmodule

// File: rtl/sdram_ctl.sv
// Top level: power-up sequencer, refresh timer and access engine. The
// engine takes over the pins once power-up is done. All pin outputs are
// registered. The data bus is driven only for a write command. Assumes
// the device shares clk.
module sdram_ctl import sdram_ctl_pkg::*; #(
    parameter int P_WAIT_CYC = 25000,
    parameter int P_PRE_CYC  = 20,
    parameter int P_REF_CYC  = 20,
    parameter int P_REF_NUM  = 8,
    parameter int P_MRD_CYC  = 2,
    parameter int P_REFI_CYC = 975,
    parameter int P_TRCD     = 2,
    parameter int P_CL       = 2,
    parameter int P_TWR      = 2,
    parameter int P_TRAS     = 6,
    parameter int P_TRP      = 3,
    parameter int P_TRFC     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_start,
    input  logic              req,
    input  logic              req_we,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    inout  wire  [DQ_W-1:0]   sd_dq
);
    sd_bus_t         init_bus, acc_bus, bus_q;
    logic            init_cke, init_done;
    logic            ref_pend, ref_ack;
    logic            dq_oe_nxt, rd_sample;
    logic [DQ_W-1:0] acc_wdata;
    logic            dq_oe_q;
    logic [DQ_W-1:0] dq_out_q;

    sdram_init_seq #(
        .P_WAIT_CYC(P_WAIT_CYC), .P_PRE_CYC(P_PRE_CYC), .P_REF_CYC(P_REF_CYC),
        .P_REF_NUM(P_REF_NUM), .P_MRD_CYC(P_MRD_CYC), .P_CL(P_CL)
    ) i_init (
        .clk(clk), .rst_n(rst_n), .start(init_start),
        .cke_nxt(init_cke), .bus_nxt(init_bus), .done(init_done)
    );

    sdram_refresh_timer #(.P_REFI_CYC(P_REFI_CYC)) i_refresh (
        .clk(clk), .rst_n(rst_n), .en(init_done), .ack(ref_ack), .pend(ref_pend)
    );

    sdram_access_fsm #(
        .P_TRCD(P_TRCD), .P_CL(P_CL), .P_TWR(P_TWR),
        .P_TRAS(P_TRAS), .P_TRP(P_TRP), .P_TRFC(P_TRFC)
    ) i_access (
        .clk(clk), .rst_n(rst_n), .init_done(init_done),
        .req(req), .req_we(req_we), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata),
        .ref_pend(ref_pend), .ref_ack(ref_ack), .busy(busy),
        .bus_nxt(acc_bus), .dq_oe_nxt(dq_oe_nxt), .wdata_q(acc_wdata),
        .rd_sample(rd_sample)
    );

    // Pin registers, pin ownership handover and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q    <= '{cmd: CMD_DES, ba: '0, addr: '0};
            sd_cke   <= 1'b0;
            dq_oe_q  <= 1'b0;
            dq_out_q <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            bus_q    <= init_done ? acc_bus : init_bus;
            sd_cke   <= init_cke;
            dq_oe_q  <= dq_oe_nxt;
            dq_out_q <= acc_wdata;
            rd_valid <= rd_sample;
            if (rd_sample) rd_data <= sd_dq;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = bus_q.cmd;
    assign sd_ba   = bus_q.ba;
    assign sd_addr = bus_q.addr;
    assign sd_dq   = dq_oe_q ? dq_out_q : 'z;

    // R7: the data bus is only driven while a write command is on the pins.
    assert_dq_only_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_q |-> (bus_q.cmd == CMD_WR));

    // R4: no row or column command before power-up has finished.
    assert_no_early_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_q.cmd == CMD_ACT || bus_q.cmd == CMD_RD || bus_q.cmd == CMD_WR) |-> init_done);

    // R8: the read strobe is a single-cycle pulse.
    assert_rd_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: tb/test_sdram_ctl.sv
// Directed bench: a behavioural device model decodes the pins and records
// timing facts; one task per scenario checks them against the requirements.
module test_sdram_ctl;
    import sdram_ctl_pkg::*;

    localparam int P_WAIT_CYC = 25000;
    localparam int P_PRE_CYC  = 20;
    localparam int P_REF_CYC  = 20;
    localparam int P_REF_NUM  = 8;
    localparam int P_REFI_CYC = 975;
    localparam int P_TRCD     = 2;
    localparam int P_CL       = 2;
    localparam int P_TWR      = 2;
    localparam int P_TRAS     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_start = 1'b0;
    logic req = 1'b0, req_we = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic [15:0] req_wdata = '0;
    logic busy, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [15:0] rd_data;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    wire  [15:0] sd_dq;

    always #2.5 clk = ~clk;

    sdram_ctl i_sdram_ctl (
        .clk(clk), .rst_n(rst_n), .init_start(init_start),
        .req(req), .req_we(req_we), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dq(sd_dq)
    );

    // ---------------- device model ----------------
    logic        model_oe = 1'b0;
    logic [15:0] model_d = '0;
    assign sd_dq = model_oe ? model_d : 'z;

    logic [15:0] mem [int unsigned];
    int cyc = 0, cs_low_n = 0, cke_seen = 0, cke_cyc = 0;
    int pre_all_n = 0, pre_all_cyc = 0, init_ref_n = 0, last_ref_cyc = 0;
    int init_bad = 0, mrs_seen = 0, mrs_n = 0, early_n = 0, illegal_n = 0;
    int act_n = 0, act_cyc = 0, col_cyc = 0, col_we = 0, min_rcd = 1000;
    int pre_n = 0, pre_bad = 0, post_ref_n = 0, max_ref_gap = 0, ref_busy_bad = 0;
    int rd_wait = 0, rd_cyc = 0;
    logic [15:0] rd_word = '0, wr_last = '0;
    logic [1:0]  act_ba = '0, col_ba = '0;
    logic [11:0] act_row = '0, col_addr = '0, mrs_addr = '0;
    logic [1:0]  mrs_ba = '0;
    logic [3:0]  cmdv;
    int unsigned k;

    function automatic int unsigned mkey(input logic [1:0] b, input logic [11:0] r, input logic [7:0] c);
        return {10'd0, b, r, c};
    endfunction

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        cmdv = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (rd_wait == 1) begin
            model_oe <= 1'b1; model_d <= rd_word; rd_wait <= 0;
        end else begin
            model_oe <= 1'b0;
            if (rd_wait > 1) rd_wait <= rd_wait - 1;
        end
        if (rst_n) begin
            if (sd_cke && cke_seen == 0) begin cke_seen <= 1; cke_cyc <= cyc; end
            if (!sd_cs_n) cs_low_n <= cs_low_n + 1;
            if (sd_cs_n || cmdv == CMD_NOP) begin
            end else if (cmdv == CMD_PRE) begin
                if (sd_addr[AP_BIT]) begin
                    pre_all_n <= pre_all_n + 1; pre_all_cyc <= cyc;
                    if (cyc - cke_cyc < P_WAIT_CYC) init_bad <= init_bad + 1;
                end else begin
                    pre_n <= pre_n + 1;
                    if (sd_ba != act_ba || cyc - act_cyc < P_TRAS ||
                        (col_we == 1 && cyc - col_cyc < P_TWR)) pre_bad <= pre_bad + 1;
                end
            end else if (cmdv == CMD_REF) begin
                if (mrs_seen == 0) begin
                    init_ref_n <= init_ref_n + 1;
                    if (init_ref_n == 0 ? (cyc - pre_all_cyc < P_PRE_CYC)
                                        : (cyc - last_ref_cyc < P_REF_CYC)) init_bad <= init_bad + 1;
                end else begin
                    post_ref_n <= post_ref_n + 1;
                    if (cyc - last_ref_cyc > max_ref_gap) max_ref_gap <= cyc - last_ref_cyc;
                    if (!busy) ref_busy_bad <= ref_busy_bad + 1;
                end
                last_ref_cyc <= cyc;
            end else if (cmdv == CMD_MRS) begin
                mrs_seen <= 1; mrs_n <= mrs_n + 1; mrs_addr <= sd_addr; mrs_ba <= sd_ba;
                if (cyc - last_ref_cyc < P_REF_CYC) init_bad <= init_bad + 1;
                last_ref_cyc <= cyc;
            end else if (cmdv == CMD_ACT) begin
                if (mrs_seen == 0) early_n <= early_n + 1;
                act_n <= act_n + 1; act_cyc <= cyc; act_ba <= sd_ba; act_row <= sd_addr;
            end else if (cmdv == CMD_WR || cmdv == CMD_RD) begin
                if (mrs_seen == 0) early_n <= early_n + 1;
                if (cyc - act_cyc < min_rcd) min_rcd <= cyc - act_cyc;
                col_cyc <= cyc; col_ba <= sd_ba; col_addr <= sd_addr;
                k = mkey(sd_ba, act_row, sd_addr[7:0]);
                if (cmdv == CMD_WR) begin
                    col_we <= 1; mem[k] = sd_dq; wr_last <= sd_dq;
                end else begin
                    col_we <= 0; rd_cyc <= cyc; rd_wait <= P_CL - 1;
                    rd_word <= mem.exists(k) ? mem[k] : 16'hDEAD;
                end
            end else illegal_n <= illegal_n + 1;
        end
    end

    // ---------------- checking ----------------
    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(sd_cke == 0, "R1 cke low in reset", sd_cke, 0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'hF, "R1 controls high in reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'hF);
        chk(busy == 1, "R1 busy in reset", busy, 1);
        chk(rd_valid == 0 && rd_data == 0, "R1 read port cleared", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sd_cke == 0 && sd_cs_n == 1, "R1 idle after reset release", sd_cs_n, 1);
    endtask

    task automatic t_wait_start();
        // Request while busy: must not be performed (R11).
        req = 1; req_we = 1; req_bank = 2'd1; req_row = 12'h0AB; req_col = 8'h12; req_wdata = 16'h1111;
        @(negedge clk);
        req = 0;
        repeat (60) @(negedge clk);
        chk(sd_cke == 0, "R2 cke low before start", sd_cke, 0);
        chk(cs_low_n == 0, "R2 no command before start", cs_low_n, 0);
    endtask

    task automatic t_init();
        init_start = 1;
        @(negedge clk);
        init_start = 0;
        repeat (40) @(negedge clk);
        // Another request while power-up is in progress (R11).
        req = 1; req_we = 1; req_bank = 2'd1; req_row = 12'h0AB; req_col = 8'h12; req_wdata = 16'h2222;
        @(negedge clk);
        req = 0;
        chk(sd_cke == 1, "R2 cke raised after start", sd_cke, 1);
        wait_ready();
        chk(init_bad == 0, "R2/R3 power-up phase spacing", init_bad, 0);
        chk(pre_all_n == 1, "R3 one precharge-all", pre_all_n, 1);
        chk(init_ref_n == P_REF_NUM, "R3 refresh count", init_ref_n, P_REF_NUM);
        chk(mrs_n == 1 && mrs_ba == 0, "R4 one mode load at bank 0", mrs_ba, 0);
        chk(mrs_addr == 12'(P_CL << 4), "R4 mode word", mrs_addr, P_CL << 4);
        chk(early_n == 0, "R4 no access before mode load", early_n, 0);
        chk(act_n == 0, "R11 busy-time request ignored", act_n, 0);
    endtask

    task automatic do_write(input logic [1:0] b, input logic [11:0] r, input logic [7:0] c, input logic [15:0] d);
        int pre0 = pre_n;
        wait_ready();
        req = 1; req_we = 1; req_bank = b; req_row = r; req_col = c; req_wdata = d;
        @(negedge clk);
        req = 0; req_we = 0; req_wdata = ~d;   // R12: changes after accept
        repeat (2) @(negedge clk);
        wait_ready();
        chk(act_ba == b && act_row == r, "R6 activate address", {act_ba, act_row}, {b, r});
        chk(col_addr == {4'd0, c} && col_ba == b, "R6 column address, A10 low", col_addr, c);
        chk(col_we == 1 && wr_last == d, "R7/R12 written word", wr_last, d);
        chk(pre_n == pre0 + 1 && pre_bad == 0, "R10 closing precharge", pre_bad, 0);
    endtask

    task automatic do_read(input logic [1:0] b, input logic [11:0] r, input logic [7:0] c, input logic [15:0] exp);
        int n = 0;
        wait_ready();
        req = 1; req_we = 0; req_bank = b; req_row = r; req_col = c;
        @(negedge clk);
        req = 0; req_we = 1;                   // R12: tag latched at accept
        while (!rd_valid && n < 100) begin @(negedge clk); n++; end
        chk(rd_valid == 1 && col_we == 0, "R12 read stays a read", col_we, 0);
        chk(rd_data == exp, "R8 read data", rd_data, exp);
        chk(cyc - rd_cyc == P_CL + 1, "R8 read latency", cyc - rd_cyc, P_CL + 1);
        @(negedge clk);
        chk(rd_valid == 0, "R8 single-cycle strobe", rd_valid, 0);
        wait_ready();
        chk(pre_bad == 0 && min_rcd >= P_TRCD, "R6/R10 row timing", min_rcd, P_TRCD);
    endtask

    task automatic t_refresh();
        int r0 = post_ref_n;
        repeat (3 * P_REFI_CYC + 10) @(negedge clk);
        chk(post_ref_n - r0 >= 2, "R9 periodic refresh", post_ref_n - r0, 2);
        chk(max_ref_gap <= P_REFI_CYC + 40, "R9 refresh gap", max_ref_gap, P_REFI_CYC);
        chk(ref_busy_bad == 0, "R9 busy during refresh", ref_busy_bad, 0);
    endtask

    task automatic t_encoding();
        chk(illegal_n == 0, "R5 only defined command codes", illegal_n, 0);
        chk(act_n > 0 && pre_n == act_n, "R5 activate/precharge decoded", pre_n, act_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_wait_start();
        t_init();
        do_write(2'd0, 12'h005, 8'h03, 16'hA5A5);
        do_write(2'd3, 12'hFFF, 8'hFF, 16'hFFFF);
        do_write(2'd2, 12'h000, 8'h00, 16'h0000);
        do_read(2'd0, 12'h005, 8'h03, 16'hA5A5);
        do_read(2'd3, 12'hFFF, 8'hFF, 16'hFFFF);
        do_read(2'd2, 12'h000, 8'h00, 16'h0000);
        do_read(2'd1, 12'h0AB, 8'h12, 16'hDEAD);   // R11: never written
        t_refresh();
        do_write(2'd1, 12'h321, 8'h7E, 16'h5A3C);
        do_read(2'd1, 12'h321, 8'h7E, 16'h5A3C);
        t_encoding();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule